// File: doc/BRIEF.md
# Interface Identifier to Logical Unit Translator

This block turns an extension interface identifier, paired with a device sequence number, into a short logical unit number that a processor can route on. A request carries two operand words. The first operand packs the identifier and the device number. The second operand carries caller data. The block searches a small associative table for the identifier and device pair. One cycle later it returns a packed word: the logical unit number sits in the low 12 bits, and the caller data sits above it.

The translation is stateless. A lookup changes nothing, and the only state is the table itself. Software, or a boot sequence, loads the table through a configuration write port that names an entry index. Two built-in fallback interfaces always resolve to unit 1 (return zero) and unit 2 (return minus one), whatever the table holds. Unit 0 is reserved to mean "not recognised".

Top module: `ifid_unit_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0, `rsp_word` is 0 and every table entry is invalid, so a lookup of any non-fallback key returns unit 0.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` high, and 0 otherwise.
- R3: Bits XLEN-1:12 of `rsp_word` equal bits XLEN-13:0 of the `req_rs2` that was presented with the request.
- R4: The lookup key is the whole `req_rs1` word: the device number in bits 11:0 and the interface identifier in bits XLEN-1:12. When a valid entry holds that key, bits 11:0 of `rsp_word` carry that entry's unit number.
- R5: When no valid entry and no fallback key matches, bits 11:0 of `rsp_word` are 0.
- R6: One identifier with different device numbers resolves independently, for example device 0 to unit 32 and device 1 to unit 34.
- R7: When several valid entries hold the same key, the entry with the lowest index supplies the unit number.
- R8: With the fallback option enabled, identifier 0xFFFFE with device 0 returns unit 1, and identifier 0xFFFFF with device 0 returns unit 2. These results take priority over any table entry with the same key. The same identifiers with any other device number get no built-in result.
- R9: A configuration write with `cfg_valid` = 0 removes the entry from matching. A lookup in the same cycle as a write sees the table as it was before that write.
- R10: `rsp_word` holds its value in every cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | Valid bit stored with the entry |
| cfg_key | input | XLEN | Identifier (XLEN-1:12) and device number (11:0) |
| cfg_unit | input | 12 | Unit number stored with the entry |
| req_valid | input | 1 | Lookup request strobe |
| req_rs1 | input | XLEN | Identifier and device key to look up |
| req_rs2 | input | XLEN | Caller data; low XLEN-12 bits are passed through |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_word | output | XLEN | Caller data in XLEN-1:12, unit number in 11:0 |

## Verification
The checker watches these properties on every cycle: the response strobe follows the request strobe one cycle later, the caller data is passed through into the upper field, the result holds between requests, fallback keys return their fixed units, and an empty table yields unit 0. Only the bench scenarios can show the table behaviour. These scenarios are: entries returning their own unit, one identifier with different device numbers landing on different units, the lowest-index winner among duplicates, invalidation of an entry, and the read-before-write ordering when a write and a lookup share a cycle.

// File: rtl/ifid_xlate_pkg.sv
package ifid_xlate_pkg;
   // Width of the logical unit number and of the device sequence field.
   localparam int LUN_W = 12;
   typedef logic [LUN_W-1:0] lun_t;
   // Unit numbers reserved for the built-in fallback interfaces.
   localparam lun_t LUN_NONE      = lun_t'(0);
   localparam lun_t LUN_RET_ZERO  = lun_t'(1);
   localparam lun_t LUN_RET_MONE  = lun_t'(2);
endpackage

// File: rtl/ifid_key_table.sv
module ifid_key_table
   import ifid_xlate_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int ENTRIES = 16,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic                     wr_vld,
   input  logic [XLEN-1:0]          wr_key,
   input  lun_t                     wr_lun,
   input  logic [XLEN-1:0]          look_key,
   output logic [ENTRIES-1:0]       hit_vec,
   output logic [ENTRIES*LUN_W-1:0] lun_flat
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic            vld_q;
      logic [XLEN-1:0] key_q;
      lun_t            lun_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            key_q <= '0;
            lun_q <= LUN_NONE;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            vld_q <= wr_vld;
            key_q <= wr_key;
            lun_q <= wr_lun;
         end
      end

      assign hit_vec[i]                  = vld_q && (key_q == look_key);
      assign lun_flat[i*LUN_W +: LUN_W]  = lun_q;
   end
endmodule

// File: rtl/ifid_hit_select.sv
module ifid_hit_select
   import ifid_xlate_pkg::*;
#(
   parameter int ENTRIES = 16
) (
   input  logic [ENTRIES-1:0]       hit_vec,
   input  logic [ENTRIES*LUN_W-1:0] lun_flat,
   output logic                     any_hit,
   output lun_t                     lun_sel
);
   // Walk from the top so the lowest matching index is assigned last.
   always_comb begin
      any_hit = 1'b0;
      lun_sel = LUN_NONE;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            any_hit = 1'b1;
            lun_sel = lun_flat[i*LUN_W +: LUN_W];
         end
      end
   end
endmodule

// File: rtl/ifid_unit_xlate.sv
module ifid_unit_xlate
   import ifid_xlate_pkg::*;
#(
   parameter int          XLEN         = 32,
   parameter int          ENTRIES      = 16,
   parameter bit          HAS_FALLBACK = 1'b1,
   parameter int unsigned FB_ZERO_ID   = 32'h000F_FFFE,
   parameter int unsigned FB_MONE_ID   = 32'h000F_FFFF,
   parameter int          IDX_W        = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IDX_W-1:0] cfg_idx,
   input  logic             cfg_valid,
   input  logic [XLEN-1:0]  cfg_key,
   input  logic [11:0]      cfg_unit,
   input  logic             req_valid,
   input  logic [XLEN-1:0]  req_rs1,
   input  logic [XLEN-1:0]  req_rs2,
   output logic             rsp_valid,
   output logic [XLEN-1:0]  rsp_word
);
   localparam int DATA_W = XLEN - LUN_W;

   // Elaboration-time parameter checks.
   if (XLEN <= LUN_W) begin : g_bad_xlen
      $error("ifid_unit_xlate: XLEN must exceed the unit field width");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("ifid_unit_xlate: ENTRIES must be at least 2");
   end
   if (IDX_W < $clog2(ENTRIES)) begin : g_bad_idx
      $error("ifid_unit_xlate: IDX_W too narrow for ENTRIES");
   end

   logic [ENTRIES-1:0]       hit_vec;
   logic [ENTRIES*LUN_W-1:0] lun_flat;
   logic                     tbl_hit;
   lun_t                     tbl_lun;
   logic                     fb_hit;
   lun_t                     fb_lun;
   lun_t                     lun_next;
   logic                     unused_rs2_hi;

   assign unused_rs2_hi = ^req_rs2[XLEN-1:DATA_W] ^ tbl_hit;

   ifid_key_table #(
      .XLEN    (XLEN),
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_idx   (cfg_idx),
      .wr_vld   (cfg_valid),
      .wr_key   (cfg_key),
      .wr_lun   (cfg_unit),
      .look_key (req_rs1),
      .hit_vec  (hit_vec),
      .lun_flat (lun_flat)
   );

   ifid_hit_select #(
      .ENTRIES (ENTRIES)
   ) u_select (
      .hit_vec  (hit_vec),
      .lun_flat (lun_flat),
      .any_hit  (tbl_hit),
      .lun_sel  (tbl_lun)
   );

   // Built-in fallback interfaces, device 0 only.
   if (HAS_FALLBACK) begin : g_fallback
      logic [XLEN-1:0] key_zero;
      logic [XLEN-1:0] key_mone;
      assign key_zero = {DATA_W'(FB_ZERO_ID), LUN_W'(0)};
      assign key_mone = {DATA_W'(FB_MONE_ID), LUN_W'(0)};
      always_comb begin
         fb_hit = 1'b1;
         if (req_rs1 == key_zero)      fb_lun = LUN_RET_ZERO;
         else if (req_rs1 == key_mone) fb_lun = LUN_RET_MONE;
         else begin
            fb_hit = 1'b0;
            fb_lun = LUN_NONE;
         end
      end
   end else begin : g_no_fallback
      assign fb_hit = 1'b0;
      assign fb_lun = LUN_NONE;
   end

   assign lun_next = fb_hit ? fb_lun : tbl_lun;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_word  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_word <= {req_rs2[DATA_W-1:0], lun_next};
         end
      end
   end
endmodule

// File: rtl/ifid_unit_xlate_chk.sv
module ifid_unit_xlate_chk #(
   parameter int          XLEN         = 32,
   parameter int          IDX_W        = 4,
   parameter bit          HAS_FALLBACK = 1'b1,
   parameter int unsigned FB_ZERO_ID   = 32'h000F_FFFE,
   parameter int unsigned FB_MONE_ID   = 32'h000F_FFFF
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [IDX_W-1:0] cfg_idx,
   input logic             cfg_valid,
   input logic             req_valid,
   input logic [XLEN-1:0]  req_rs1,
   input logic [XLEN-1:0]  req_rs2,
   input logic             rsp_valid,
   input logic [XLEN-1:0]  rsp_word
);
   localparam int LW = 12;
   localparam int DW = XLEN - LW;

   logic            any_loaded;
   logic            is_zero_key;
   logic            is_mone_key;
   logic [IDX_W-1:0] unused_idx;

   assign unused_idx  = cfg_idx;
   assign is_zero_key = HAS_FALLBACK && (req_rs1 == {DW'(FB_ZERO_ID), LW'(0)});
   assign is_mone_key = HAS_FALLBACK && (req_rs1 == {DW'(FB_MONE_ID), LW'(0)});

   always_ff @(posedge clk) begin
      if (!rst_n)                        any_loaded <= 1'b0;
      else if (cfg_we && cfg_valid)      any_loaded <= 1'b1;
   end

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2
   AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R2
   AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_word[XLEN-1:LW] == $past(req_rs2[DW-1:0])); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(rsp_word)); // R10
   AST_FB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_zero_key) |=> rsp_word[LW-1:0] == LW'(1)); // R8
   AST_FB_MONE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_mone_key) |=> rsp_word[LW-1:0] == LW'(2)); // R8
   AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !any_loaded && !is_zero_key && !is_mone_key)
         |=> rsp_word[LW-1:0] == LW'(0)); // R5
endmodule

bind ifid_unit_xlate ifid_unit_xlate_chk #(
   .XLEN         (XLEN),
   .IDX_W        (IDX_W),
   .HAS_FALLBACK (HAS_FALLBACK),
   .FB_ZERO_ID   (FB_ZERO_ID),
   .FB_MONE_ID   (FB_MONE_ID)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_idx   (cfg_idx),
   .cfg_valid (cfg_valid),
   .req_valid (req_valid),
   .req_rs1   (req_rs1),
   .req_rs2   (req_rs2),
   .rsp_valid (rsp_valid),
   .rsp_word  (rsp_word)
);

// File: tb/ifid_unit_xlate_tb.sv
`timescale 1ns/1ps
module ifid_unit_xlate_tb;
   localparam int XLEN  = 32;
   localparam int IDX_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [IDX_W-1:0] cfg_idx = '0;
   logic             cfg_valid = 1'b0;
   logic [XLEN-1:0]  cfg_key = '0;
   logic [11:0]      cfg_unit = '0;
   logic             req_valid = 1'b0;
   logic [XLEN-1:0]  req_rs1 = '0;
   logic [XLEN-1:0]  req_rs2 = '0;
   logic             rsp_valid;
   logic [XLEN-1:0]  rsp_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ifid_unit_xlate u_dut (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_idx (cfg_idx), .cfg_valid (cfg_valid),
      .cfg_key (cfg_key), .cfg_unit (cfg_unit),
      .req_valid (req_valid), .req_rs1 (req_rs1), .req_rs2 (req_rs2),
      .rsp_valid (rsp_valid), .rsp_word (rsp_word)
   );

   task automatic check(input string req, input logic [XLEN-1:0] got,
                        input logic [XLEN-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [XLEN-1:0] key(input logic [19:0] id, input logic [11:0] dev);
      return {id, dev};
   endfunction

   task automatic put(input int idx, input bit vld, input logic [XLEN-1:0] k,
                      input logic [11:0] lun);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_valid = vld;
      cfg_key = k; cfg_unit = lun;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Issue one lookup and check the full response word one cycle later.
   task automatic look(input string req, input logic [XLEN-1:0] rs1,
                       input logic [XLEN-1:0] rs2, input logic [11:0] exp_lun);
      @(negedge clk);
      req_valid = 1'b1; req_rs1 = rs1; req_rs2 = rs2;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, {31'b0, rsp_valid}, 32'd1);
      check(req, rsp_word, {rs2[19:0], exp_lun});
   endtask

   task automatic t_reset();
      check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
      check("R1 rsp_word after reset", rsp_word, 32'd0);
      look("R1 R5 empty table miss", key(20'h12345, 12'h000), 32'hCAFE_0123, 12'd0);
   endtask

   task automatic t_device_split();
      put(3, 1'b1, key(20'h12345, 12'h000), 12'd32);
      put(7, 1'b1, key(20'h12345, 12'h001), 12'd34);
      look("R4 R6 id 12345 dev 0", key(20'h12345, 12'h000), 32'h0000_1111, 12'd32);
      look("R4 R6 id 12345 dev 1", key(20'h12345, 12'h001), 32'h0000_2222, 12'd34);
      look("R5 id 12345 dev 2 miss", key(20'h12345, 12'h002), 32'h0000_3333, 12'd0);
   endtask

   task automatic t_data_pass();
      look("R3 rs2 all ones", key(20'h12345, 12'h000), 32'hFFFF_FFFF, 12'd32);
      look("R3 rs2 pattern", key(20'h99999, 12'h000), 32'h5A5A_5A5A, 12'd0);
   endtask

   task automatic t_idle_hold();
      logic [XLEN-1:0] prev;
      prev = rsp_word;
      @(negedge clk);
      check("R2 no request no valid", {31'b0, rsp_valid}, 32'd0);
      check("R10 word held while idle", rsp_word, prev);
   endtask

   task automatic t_priority();
      put(9, 1'b1, key(20'hABCDE, 12'h005), 12'd41);
      put(2, 1'b1, key(20'hABCDE, 12'h005), 12'd40);
      look("R7 lowest index wins", key(20'hABCDE, 12'h005), 32'h0000_0000, 12'd40);
      put(2, 1'b0, key(20'hABCDE, 12'h005), 12'd40);
      look("R9 invalidated entry skipped", key(20'hABCDE, 12'h005), 32'h0000_0000, 12'd41);
   endtask

   task automatic t_fallback();
      look("R8 return-zero interface", key(20'hFFFFE, 12'h000), 32'h0000_0044, 12'd1);
      look("R8 return-minus-one interface", key(20'hFFFFF, 12'h000), 32'h0000_0055, 12'd2);
      put(0, 1'b1, key(20'hFFFFE, 12'h000), 12'd99);
      look("R8 fallback over table", key(20'hFFFFE, 12'h000), 32'h0000_0066, 12'd1);
      look("R8 fallback id other device", key(20'hFFFFF, 12'h003), 32'h0000_0077, 12'd0);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 4'd5; cfg_valid = 1'b1;
      cfg_key = key(20'h0D0B0, 12'h000); cfg_unit = 12'd35;
      req_valid = 1'b1; req_rs1 = key(20'h0D0B0, 12'h000); req_rs2 = 32'h0000_0ABC;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      check("R9 lookup sees pre-write table", rsp_word, {20'h00000, 12'd0} | 32'h00AB_C000);
      look("R9 lookup after write", key(20'h0D0B0, 12'h000), 32'h0000_0ABC, 12'd35);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_device_split();
      t_data_pass();
      t_idle_hold();
      t_priority();
      t_fallback();
      t_same_cycle();
      summary();
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end
endmodule